// File: doc/BRIEF.md
# Transaction-Layer Packet Transmit Framer

This block turns one memory read, memory write or completion request at a time into a PCI Express transaction-layer packet. It sends the packet as a series of 64-bit beats on a streaming output. The output carries start, end, half-beat and valid flags, and a ready input from the sink pauses it. The requester holds a request steady until the block signals done. The request gives the kind of transfer, a 64-bit-aligned byte address (bits 63:3), a transfer size counted in 64-bit words, a tag, the local and remote identifiers, and one 64-bit data word.

The framer builds the header from these fields. A short 3DW header is used when the address lies below 4 GiB, and a long 4DW header is used otherwise. Behind a 3DW header, each 64-bit data word splits across two beats, and the packet then ends on a half-filled beat. Behind a 4DW header, the data words go out whole. While the block needs write data, it raises an accept strobe. On each edge where accept is high, it takes the word on the data input, and the requester must then present the next word.

Top module: `tlp_tx_framer`

## Requirements
- R1: When no packet is in flight, the beat data and every strobe (`tx_sof`, `tx_eof`, `tx_half`, `tx_valid`, `req_accept`, `req_done`) are zero. This includes the cycles during and just after reset.
- R2: A request is sent with the 4DW header when byte address bits 63:32 are not all zero, and with the 3DW header when they are. Header bits 62:61 hold the format: 00 for a short read, 01 for a long read, 10 for a short write, 11 for a long write. Bits 60:56 hold the type 00000, and bits 55:42 are zero.
- R3: Header bits 41:32 hold twice the word count, where a count of zero counts as one word. Header bits 7:0 hold the byte enables: 0x0F for one word and 0xFF for more.
- R4: Header bits 31:16 hold the local ID. Bits 15:8 hold the tag zero-extended to 8 bits for a read, and 0x00 for a write.
- R5: A short read is two beats. The second beat is the byte address bits 31:0 in beat bits 63:32, with zeros below, and has `tx_eof` and `tx_half` set.
- R6: A long read is two beats. The second beat is the full 64-bit byte address, with `tx_eof` set and `tx_half` clear.
- R7: In a short write of N words, beat 2 is {address bits 31:0, word0 bits 63:32}. Beat k+2 (k = 1..N-1) is {word(k-1) bits 31:0, word k bits 63:32}. The last beat is {word(N-1) bits 31:0, 32 zero bits} with `tx_eof` and `tx_half` set. `tx_half` is never set without `tx_eof`.
- R8: A long write of N words is a header beat, then the 64-bit address beat, then N beats each carrying one whole data word. Only the last of these has `tx_eof` set, and `tx_half` stays clear.
- R9: A completion is three beats. Beat 1 is {0, format 10, type 01010, 14 zero bits, length 2, local ID, 16'h0008}. Beat 2 is {remote ID, tag as 8 bits, 0, address bits 6:0, data bits 63:32}. Beat 3 is {data bits 31:0, 32 zero bits} with `tx_eof` and `tx_half` set.
- R10: While `tx_valid` is high and `tx_ready` is low, the next cycle shows the same beat and the same `tx_sof`/`tx_eof`/`tx_half` flags.
- R11: `req_done` is high exactly when the beat with `tx_eof` is shown and `tx_ready` is high. The cycle after it is idle.
- R12: `req_accept` is high when `tx_ready` is high on these beats: the header beat of a short write and every short-write data beat that has a later word still to take, and the address beat of a long write and every long-write data beat except the last. It is never high for reads or completions.
- R13: When several request kinds are raised together, read wins over write and write wins over completion.
- R14: `tx_sof` is set on the first beat of each packet only, and `tx_valid` stays high on every beat of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | 1 | Memory read request |
| req_wr | input | 1 | Memory write request |
| req_cpl | input | 1 | Completion-with-data request |
| req_addr | input | 61 | Byte address bits 63:3 |
| req_words | input | LEN_W (9) | Transfer size in 64-bit words, 0 means 1 |
| req_tag | input | TAG_W (5) | Transaction tag |
| req_local_id | input | 16 | Identifier of this function |
| req_remote_id | input | 16 | Identifier of the original requester (completions) |
| req_data | input | 64 | Current payload word |
| req_accept | output | 1 | Payload word taken at this edge |
| req_done | output | 1 | Final beat leaves at this edge |
| tx_data | output | 64 | Beat data |
| tx_sof | output | 1 | First beat of packet |
| tx_eof | output | 1 | Last beat of packet |
| tx_half | output | 1 | Only upper 32 bits of this beat are used |
| tx_valid | output | 1 | Beat present |
| tx_ready | input | 1 | Sink takes the beat at this edge |

## Verification
Assertions check the handshake rules on every cycle: beats held under back-pressure, quiet idle outputs, start flags only after idle, half flags only on end beats, accept never on an end beat, and idle right after done. Only the bench scenarios can show the content of each beat. That covers the header fields, the choice between header lengths, the half-beat shift of write data, the completion layout and the priority between request kinds. The bench compares each of these against beats it builds from the requirements, with and without stalls from the sink.

// File: rtl/tlp_tx_pkg.sv
`timescale 1ns/1ps
package tlp_tx_pkg;

  localparam int BEAT_W = 64;
  localparam int DW_W   = 32;
  localparam int ID_W   = 16;
  localparam int LENF_W = 10;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_RD,
    KIND_WR,
    KIND_CPL
  } kind_e;

  // Meaning of the beat currently on the output
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_RDA,
    ST_D32,
    ST_WA64,
    ST_D64,
    ST_CPL,
    ST_TAIL
  } beat_e;

  localparam logic [1:0] FMT_RD3   = 2'b00;
  localparam logic [1:0] FMT_RD4   = 2'b01;
  localparam logic [1:0] FMT_WR3   = 2'b10;
  localparam logic [1:0] FMT_WR4   = 2'b11;
  localparam logic [4:0] TYPE_MEM  = 5'b00000;
  localparam logic [4:0] TYPE_CPLD = 5'b01010;

endpackage

// File: rtl/tlp_req_arb.sv
`timescale 1ns/1ps
module tlp_req_arb
  import tlp_tx_pkg::*;
(
  input  logic  rd_i,
  input  logic  wr_i,
  input  logic  cpl_i,
  output kind_e kind_o
);

  // Fixed priority: read, then write, then completion (R13)
  always_comb begin
    if (rd_i)       kind_o = KIND_RD;
    else if (wr_i)  kind_o = KIND_WR;
    else if (cpl_i) kind_o = KIND_CPL;
    else            kind_o = KIND_NONE;
  end

endmodule

// File: rtl/tlp_hdr_gen.sv
`timescale 1ns/1ps
module tlp_hdr_gen
  import tlp_tx_pkg::*;
#(
  parameter int LEN_W = 9,
  parameter int TAG_W = 5
) (
  input  kind_e             kind_i,
  input  logic [63:3]       addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [ID_W-1:0]   lid_i,
  input  logic [ID_W-1:0]   rid_i,
  output logic [BEAT_W-1:0] hdr_o,
  output logic [DW_W-1:0]   addr_dw_o,
  output logic [BEAT_W-1:0] addr_qw_o,
  output logic [DW_W-1:0]   cpl_dw_o,
  output logic              wide_o,
  output logic [LEN_W-1:0]  words_o
);

  logic [LENF_W-1:0] len_field;
  logic [7:0]        tag8;
  logic [7:0]        be;
  logic [1:0]        fmt;
  logic [DW_W-1:0]   dw0;
  logic [DW_W-1:0]   dw1;

  assign wide_o    = |addr_i[63:32];
  assign words_o   = (len_i == '0) ? LEN_W'(1) : len_i;
  assign len_field = LENF_W'({words_o, 1'b0});

  always_comb begin
    tag8 = '0;
    tag8[TAG_W-1:0] = tag_i;
    be  = (words_o == LEN_W'(1)) ? 8'h0F : 8'hFF;
    fmt = 2'b00;
    dw0 = '0;
    dw1 = '0;
    case (kind_i)
      KIND_RD: begin
        fmt = wide_o ? FMT_RD4 : FMT_RD3;
        dw0 = {1'b0, fmt, TYPE_MEM, 14'd0, len_field};
        dw1 = {lid_i, tag8, be};
      end
      KIND_WR: begin
        fmt = wide_o ? FMT_WR4 : FMT_WR3;
        dw0 = {1'b0, fmt, TYPE_MEM, 14'd0, len_field};
        dw1 = {lid_i, 8'h00, be};
      end
      KIND_CPL: begin
        fmt = FMT_WR3;
        dw0 = {1'b0, fmt, TYPE_CPLD, 14'd0, 10'd2};
        dw1 = {lid_i, 3'b000, 1'b0, 12'd8};
      end
      default: begin
        fmt = 2'b00;
      end
    endcase
  end

  assign hdr_o     = {dw0, dw1};
  assign addr_dw_o = {addr_i[31:3], 3'b000};
  assign addr_qw_o = {addr_i, 3'b000};
  assign cpl_dw_o  = {rid_i, tag8, 1'b0, addr_i[6:3], 3'b000};

endmodule

// File: rtl/tlp_beat_seq.sv
`timescale 1ns/1ps
module tlp_beat_seq
  import tlp_tx_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  kind_e             kind_i,
  input  logic              wide_i,
  input  logic [LEN_W-1:0]  words_i,
  input  logic [BEAT_W-1:0] hdr_i,
  input  logic [DW_W-1:0]   addr_dw_i,
  input  logic [BEAT_W-1:0] addr_qw_i,
  input  logic [DW_W-1:0]   cpl_dw_i,
  input  logic [BEAT_W-1:0] din_i,
  input  logic              ready_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              half_o,
  output logic              valid_o,
  output logic              accept_o,
  output logic              done_o
);

  beat_e             st_q,   st_d;
  kind_e             kind_q, kind_d;
  logic              wide_q, wide_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              sof_q,  sof_d;
  logic              eof_q,  eof_d;
  logic              half_q, half_d;
  logic              want_q, want_d;
  logic [LEN_W-1:0]  rem_q,  rem_d;
  logic [DW_W-1:0]   lo_q,   lo_d;

  logic              en;
  logic [LEN_W-1:0]  rem_after;
  logic              more;

  assign en        = (st_q == ST_IDLE) || ready_i;
  assign rem_after = want_q ? (rem_q - LEN_W'(1)) : rem_q;
  assign more      = (rem_after != '0);

  // Next-beat computation
  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    wide_d = wide_q;
    beat_d = beat_q;
    sof_d  = sof_q;
    eof_d  = eof_q;
    half_d = half_q;
    want_d = want_q;
    rem_d  = rem_q;
    lo_d   = lo_q;
    if (st_q == ST_IDLE || eof_q) begin
      st_d   = ST_IDLE;
      kind_d = KIND_NONE;
      wide_d = 1'b0;
      beat_d = '0;
      sof_d  = 1'b0;
      eof_d  = 1'b0;
      half_d = 1'b0;
      want_d = 1'b0;
      rem_d  = '0;
      lo_d   = '0;
      if (st_q == ST_IDLE && kind_i != KIND_NONE) begin
        st_d   = ST_HDR;
        kind_d = kind_i;
        wide_d = wide_i;
        beat_d = hdr_i;
        sof_d  = 1'b1;
        want_d = (kind_i == KIND_WR) && !wide_i;
        rem_d  = words_i;
      end
    end else begin
      sof_d = 1'b0;
      rem_d = rem_after;
      case (st_q)
        ST_HDR: begin
          case (kind_q)
            KIND_RD: begin
              st_d   = ST_RDA;
              eof_d  = 1'b1;
              half_d = !wide_q;
              want_d = 1'b0;
              beat_d = wide_q ? addr_qw_i : {addr_dw_i, {DW_W{1'b0}}};
            end
            KIND_WR: begin
              if (wide_q) begin
                st_d   = ST_WA64;
                beat_d = addr_qw_i;
                want_d = 1'b1;
              end else begin
                st_d   = ST_D32;
                beat_d = {addr_dw_i, din_i[63:32]};
                lo_d   = din_i[31:0];
                want_d = more;
              end
            end
            default: begin
              st_d   = ST_CPL;
              beat_d = {cpl_dw_i, din_i[63:32]};
              lo_d   = din_i[31:0];
              want_d = 1'b0;
            end
          endcase
        end
        ST_D32: begin
          if (want_q) begin
            beat_d = {lo_q, din_i[63:32]};
            lo_d   = din_i[31:0];
            want_d = more;
          end else begin
            st_d   = ST_TAIL;
            beat_d = {lo_q, {DW_W{1'b0}}};
            eof_d  = 1'b1;
            half_d = 1'b1;
          end
        end
        ST_CPL: begin
          st_d   = ST_TAIL;
          beat_d = {lo_q, {DW_W{1'b0}}};
          eof_d  = 1'b1;
          half_d = 1'b1;
        end
        ST_WA64, ST_D64: begin
          st_d   = ST_D64;
          beat_d = din_i;
          eof_d  = !more;
          want_d = more;
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  // State and beat registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= KIND_NONE;
      wide_q <= 1'b0;
      beat_q <= '0;
      sof_q  <= 1'b0;
      eof_q  <= 1'b0;
      half_q <= 1'b0;
      want_q <= 1'b0;
      rem_q  <= '0;
      lo_q   <= '0;
    end else if (en) begin
      st_q   <= st_d;
      kind_q <= kind_d;
      wide_q <= wide_d;
      beat_q <= beat_d;
      sof_q  <= sof_d;
      eof_q  <= eof_d;
      half_q <= half_d;
      want_q <= want_d;
      rem_q  <= rem_d;
      lo_q   <= lo_d;
    end
  end

  assign beat_o   = beat_q;
  assign sof_o    = sof_q;
  assign eof_o    = eof_q;
  assign half_o   = half_q;
  assign valid_o  = (st_q != ST_IDLE);
  assign accept_o = want_q && ready_i;
  assign done_o   = eof_q && ready_i;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (beat_o == '0) && !sof_o && !eof_o && !half_o && !accept_o && !done_o)
    else $error("idle outputs not zero");

  assert_hold_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> valid_o && $stable(beat_o) && $stable({sof_o, eof_o, half_o}))
    else $error("beat changed under back-pressure");

  assert_half_on_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    half_o |-> eof_o && valid_o)
    else $error("half flag away from end beat");

  assert_idle_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !valid_o)
    else $error("packet continued after done");

  assert_no_accept_on_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> valid_o && !eof_o && !sof_o || accept_o && sof_o && !eof_o)
    else $error("accept on end beat");

  assert_start_after_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> sof_o)
    else $error("packet began without start flag");

endmodule

// File: rtl/tlp_tx_framer.sv
`timescale 1ns/1ps
module tlp_tx_framer
  import tlp_tx_pkg::*;
#(
  parameter int LEN_W = 9,
  parameter int TAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic              req_cpl,
  input  logic [63:3]       req_addr,
  input  logic [LEN_W-1:0]  req_words,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [15:0]       req_local_id,
  input  logic [15:0]       req_remote_id,
  input  logic [63:0]       req_data,
  output logic              req_accept,
  output logic              req_done,
  output logic [63:0]       tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              tx_half,
  output logic              tx_valid,
  input  logic              tx_ready
);

  logic [1:0]        rsync_q;
  logic              rst_int_n;
  kind_e             kind;
  logic [BEAT_W-1:0] hdr;
  logic [DW_W-1:0]   addr_dw;
  logic [BEAT_W-1:0] addr_qw;
  logic [DW_W-1:0]   cpl_dw;
  logic              wide;
  logic [LEN_W-1:0]  words;

  // Reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  tlp_req_arb i_arb (
    .rd_i   (req_rd),
    .wr_i   (req_wr),
    .cpl_i  (req_cpl),
    .kind_o (kind)
  );

  tlp_hdr_gen #(.LEN_W(LEN_W), .TAG_W(TAG_W)) i_hdr (
    .kind_i    (kind),
    .addr_i    (req_addr),
    .len_i     (req_words),
    .tag_i     (req_tag),
    .lid_i     (req_local_id),
    .rid_i     (req_remote_id),
    .hdr_o     (hdr),
    .addr_dw_o (addr_dw),
    .addr_qw_o (addr_qw),
    .cpl_dw_o  (cpl_dw),
    .wide_o    (wide),
    .words_o   (words)
  );

  tlp_beat_seq #(.LEN_W(LEN_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .kind_i    (kind),
    .wide_i    (wide),
    .words_i   (words),
    .hdr_i     (hdr),
    .addr_dw_i (addr_dw),
    .addr_qw_i (addr_qw),
    .cpl_dw_i  (cpl_dw),
    .din_i     (req_data),
    .ready_i   (tx_ready),
    .beat_o    (tx_data),
    .sof_o     (tx_sof),
    .eof_o     (tx_eof),
    .half_o    (tx_half),
    .valid_o   (tx_valid),
    .accept_o  (req_accept),
    .done_o    (req_done)
  );

endmodule

// File: tb/test_tlp_tx_framer.sv
`timescale 1ns/1ps
module test_tlp_tx_framer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_rd = 1'b0, req_wr = 1'b0, req_cpl = 1'b0;
  logic [63:3] req_addr = '0;
  logic [8:0]  req_words = '0;
  logic [4:0]  req_tag = '0;
  logic [15:0] req_local_id = '0, req_remote_id = '0;
  logic [63:0] req_data = '0;
  logic        req_accept, req_done;
  logic [63:0] tx_data;
  logic        tx_sof, tx_eof, tx_half, tx_valid;
  logic        tx_ready = 1'b0;

  always #4 clk = ~clk;

  tlp_tx_framer i_tlp_tx_framer (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_cpl(req_cpl),
    .req_addr(req_addr), .req_words(req_words), .req_tag(req_tag),
    .req_local_id(req_local_id), .req_remote_id(req_remote_id), .req_data(req_data),
    .req_accept(req_accept), .req_done(req_done), .tx_data(tx_data), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .tx_half(tx_half), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  typedef struct packed {
    logic [63:0] d;
    logic        sof, eof, half, acc, dn;
  } beat_t;

  beat_t       exp_q[$];
  string       lbl_q[$];
  int          checks = 0;
  int          fails = 0;
  bit          finished = 1'b0;
  int          cyc = 0;
  logic [63:0] wd [0:7];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  task automatic push(input logic [63:0] d, input logic s, e, h, a, dn, input string l);
    exp_q.push_back(beat_t'{d, s, e, h, a, dn});
    lbl_q.push_back(l);
  endtask

  // Monitor: compares each transferred beat with the scoreboard
  beat_t act, held, exp_b;
  bit    held_v = 1'b0, prev_done = 1'b0;
  string lbl;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      act = beat_t'{tx_data, tx_sof, tx_eof, tx_half, req_accept, req_done};
      if (prev_done)
        check(!tx_valid, "R11", $sformatf("valid after done: actual %b expected 0", tx_valid));
      if (held_v)
        check(tx_valid && act[68:3] == held[68:3], "R10",
              $sformatf("held beat: actual %h expected %h", act, held));
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R14", $sformatf("unexpected beat: actual %h expected none", act));
        end else begin
          exp_b = exp_q.pop_front();
          lbl   = lbl_q.pop_front();
          check(act == exp_b, lbl, $sformatf("beat: actual %h expected %h", act, exp_b));
        end
      end else if (!tx_valid) begin
        check(act == '0, "R1", $sformatf("idle outputs: actual %h expected 0", act));
      end
      held_v    = tx_valid && !tx_ready;
      held      = act;
      prev_done = req_done;
    end
  end

  // Driver: builds the expected packet, then presents the request
  task automatic send(input bit rd, wr, cp, input logic [63:0] addr, input int n,
                      input logic [4:0] tg, input logic [15:0] lid, rid, input bit stall);
    bit          wide;
    int          ne;
    logic [9:0]  lenf;
    logic [7:0]  be;
    logic [63:0] h;
    int          idx;
    bit          acc, dn;
    wide = (addr[63:32] != 32'd0);
    ne   = (n == 0) ? 1 : n;
    lenf = 10'(ne * 2);
    be   = (ne == 1) ? 8'h0F : 8'hFF;
    if (rd) begin                                   // R13: read wins
      h = {1'b0, wide ? 2'b01 : 2'b00, 5'b0, 14'b0, lenf, lid, 3'b000, tg, be};
      push(h, 1, 0, 0, 0, 0, "R3");
      if (wide) push(addr, 0, 1, 0, 0, 1, "R6");
      else      push({addr[31:0], 32'h0}, 0, 1, 1, 0, 1, "R5");
    end else if (wr) begin                          // R13: write over completion
      h = {1'b0, wide ? 2'b11 : 2'b10, 5'b0, 14'b0, lenf, lid, 8'h00, be};
      if (!wide) begin
        push(h, 1, 0, 0, 1, 0, "R4");
        push({addr[31:0], wd[0][63:32]}, 0, 0, 0, ne > 1, 0, "R12");
        for (int k = 1; k < ne; k++)
          push({wd[k-1][31:0], wd[k][63:32]}, 0, 0, 0, k < ne - 1, 0, "R7");
        push({wd[ne-1][31:0], 32'h0}, 0, 1, 1, 0, 1, "R7");
      end else begin
        push(h, 1, 0, 0, 0, 0, "R2");
        push(addr, 0, 0, 0, 1, 0, "R8");
        for (int k = 0; k < ne; k++)
          push(wd[k], 0, k == ne - 1, 0, k < ne - 1, k == ne - 1, "R8");
      end
    end else begin
      push({1'b0, 2'b10, 5'b01010, 14'b0, 10'd2, lid, 16'h0008}, 1, 0, 0, 0, 0, "R9");
      push({rid, 3'b000, tg, 1'b0, addr[6:0], wd[0][63:32]}, 0, 0, 0, 0, 0, "R9");
      push({wd[0][31:0], 32'h0}, 0, 1, 1, 0, 1, "R9");
    end
    @(posedge clk); #1;
    req_rd = rd; req_wr = wr; req_cpl = cp;
    req_addr = addr[63:3]; req_words = 9'(n); req_tag = tg;
    req_local_id = lid; req_remote_id = rid;
    idx = 0;
    req_data = wd[0];
    forever begin
      tx_ready = stall ? ((cyc % 3) != 2) : 1'b1;
      @(negedge clk);
      acc = req_accept;
      dn  = req_done;
      @(posedge clk); #1;
      if (acc) begin
        idx++;
        req_data = wd[idx % 8];
      end
      if (dn) break;
    end
    req_rd = 0; req_wr = 0; req_cpl = 0; req_addr = '0; req_words = '0;
    req_tag = '0; req_local_id = '0; req_remote_id = '0; req_data = '0;
    tx_ready = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) wd[i] = {8{8'h11 * 8'(i + 1)}} ^ 64'h0123_4567_89AB_CDEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({tx_data, tx_sof, tx_eof, tx_half, tx_valid, req_accept, req_done} == '0, "R1",
          $sformatf("reset outputs: actual %h expected 0", tx_data));
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    send(1, 0, 0, 64'h0000_0000_0000_0008, 1, 5'h0A, 16'hAAAA, 16'h0, 1);  // short read, stalls
    send(0, 1, 0, 64'h0000_0000_0000_0010, 2, 5'h00, 16'hBBBB, 16'h0, 0);  // short write
    send(0, 0, 1, 64'h0000_0000_0000_0018, 1, 5'h0C, 16'hAAAA, 16'hBBBB, 0); // completion
    send(1, 0, 0, 64'h8000_0000_0000_0000, 3, 5'h0C, 16'hCCCC, 16'h0, 0);  // long read
    send(0, 1, 0, 64'h8000_0000_0000_0000, 1, 5'h00, 16'hAAAA, 16'h0, 0);  // long write, one word
    send(0, 1, 0, 64'h0000_0000_1234_5678, 3, 5'h00, 16'h1357, 16'h0, 1);  // short write, stalls
    send(0, 1, 0, 64'h0000_0001_0000_0040, 4, 5'h00, 16'h2468, 16'h0, 1);  // long write, stalls
    send(1, 0, 0, 64'h0000_0000_0000_0100, 0, 5'h1F, 16'h0F0F, 16'h0, 0);  // zero length read
    send(0, 1, 0, 64'h0000_0000_0000_0200, 0, 5'h00, 16'h0F0F, 16'h0, 0);  // zero length write
    send(1, 1, 1, 64'h0000_0000_0000_0300, 2, 5'h05, 16'h5555, 16'h6666, 0); // R13 read wins
    send(0, 1, 1, 64'h0000_0000_0000_0400, 1, 5'h06, 16'h7777, 16'h8888, 0); // R13 write wins
    send(0, 0, 1, 64'h0000_0000_0000_0478, 1, 5'h13, 16'h9999, 16'hABCD, 1); // completion, stalls
    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "R11",
          $sformatf("beats left: actual %0d expected 0", exp_q.size()));
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R11 watchdog: actual hung, expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule